// File: doc/BRIEF.md
# Closed-Caption Line Serializer

This block builds the digital bit stream for a closed-caption data line, once per video field, on a single line chosen by the host. The host writes two bytes for each field into holding registers: the odd-field pair carries caption text and the even-field pair carries extended data. When the line-start pulse arrives on the chosen line, the block waits a programmed number of pixel clocks. It then sends, with no gaps, a clock run-in, a three-bit framing code and the sixteen data bits of the current field's pair.

Every bit is held for a programmed number of pixel clocks. A one-cycle strobe marks the first cycle of each bit, and a data-active flag covers the whole burst, so a downstream modulator can shape the waveform. Bytes go out least significant bit first. The host supplies the parity bit in bit 7 of each byte. The block only reports a byte that lacks odd parity and sends it unchanged. The pair to be sent is captured when the burst is triggered, so a host write during a burst never mixes old and new bytes.

Control is a five-state machine:
- `ST_IDLE` moves to `ST_WAIT` on a line start on the matching line.
- `ST_WAIT` moves to `ST_RUNIN` when the delay count is reached.
- `ST_RUNIN` moves to `ST_FRAME` after the fourteenth run-in bit.
- `ST_FRAME` moves to `ST_DATA` after the third framing bit.
- `ST_DATA` moves back to `ST_IDLE` after the sixteenth data bit.

Top module: `cc_line_serializer`

## Requirements
- R1: After reset, `data_active`, `bit_strobe`, `ser_bit` and `parity_err` are all 0.
- R2: A `line_start` pulse sampled while `line_num` differs from `caption_line` starts no burst.
- R3: With `line_start` sampled high on matching line at clock edge E0, `data_active` rises after edge E0+`start_delay`+1 and stays high for exactly 33 bit periods.
- R4: Each bit lasts P clock cycles, where P = `bit_period`, or 1 when `bit_period` is 0. `bit_strobe` is high only in the first cycle of each bit.
- R5: Bits 0 to 13 of the burst are the run-in: 1 on even bit numbers and 0 on odd ones.
- R6: Bits 14, 15 and 16 are the framing code 0, 0, 1.
- R7: Bits 17 to 24 are the first byte, bit 0 first. Bits 25 to 32 are the second byte, bit 0 first. `data_active` falls right after bit 32.
- R8: With `field_odd`=1 the odd pair is sent; with `field_odd`=0 the even pair. `wr_en` bit 0 writes the odd first byte, bit 1 the odd second byte, bit 2 the even first byte and bit 3 the even second byte, from `wr_data`.
- R9: During the bits of a byte whose 8 bits hold an even number of ones, `parity_err` is 1. It is 0 at all other times, and the stream is the same as for any other byte.
- R10: Bytes written after a burst has been triggered do not change that burst. They are sent from the next triggered burst onward.
- R11: A `line_start` pulse during a burst neither restarts nor extends it.
- R12: `ser_bit` is 0 whenever `data_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each video line |
| field_odd | input | 1 | 1 for the odd field, 0 for the even field |
| line_num | input | LINE_W | Number of the current line |
| caption_line | input | LINE_W | Line that carries caption data |
| start_delay | input | CNT_W | Clocks from line start to the first bit, minus one |
| bit_period | input | CNT_W | Clocks per bit (0 acts as 1) |
| wr_en | input | 4 | Byte register write enables, one per byte |
| wr_data | input | 8 | Byte value to write |
| ser_bit | output | 1 | Serial data bit |
| bit_strobe | output | 1 | High in the first cycle of each bit |
| data_active | output | 1 | High for the whole burst |
| parity_err | output | 1 | Current data byte lacks odd parity |

## Verification
Two pairs of functions can meet in one cycle. A host write can land in the middle of a burst, and a new line-start pulse can arrive while a burst is still running. The bench provokes both in the same cycle inside a burst. It then judges that every bit of the running burst still matches the bytes captured at its trigger, that the burst ends on time, and that the next bursts of both fields carry the new bytes. A sweep over bit periods 0 to 3, three delays and both fields compares every cycle of every burst against a bit position computed in the bench.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUNIN,
        ST_FRAME,
        ST_DATA
    } cc_state_e;

    localparam int RUNIN_BITS = 14;
    localparam int FRAME_BITS = 3;
    localparam int DATA_BITS  = 16;
    localparam int TOTAL_BITS = RUNIN_BITS + FRAME_BITS + DATA_BITS;
    localparam int IDX_W      = $clog2(TOTAL_BITS);
endpackage

// File: rtl/cc_byte_bank.sv
module cc_byte_bank #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load,
    input  logic              load_odd,
    output logic [BYTE_W-1:0] tx_first,
    output logic [BYTE_W-1:0] tx_second
);
    logic [BYTE_W-1:0] pend_q [4];

    for (genvar g = 0; g < 4; g++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q[g] <= '0;
            else if (wr_en[g])
                pend_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_first  <= '0;
            tx_second <= '0;
        end else if (load) begin
            tx_first  <= load_odd ? pend_q[0] : pend_q[2];
            tx_second <= load_odd ? pend_q[1] : pend_q[3];
        end
    end
endmodule

// File: rtl/cc_phase_counter.sv
module cc_phase_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] phase,
    output logic             at_limit
);
    assign at_limit = (phase == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (hold || at_limit)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/cc_line_serializer.sv
module cc_line_serializer
    import cc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              field_odd,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] caption_line,
    input  logic [CNT_W-1:0]  start_delay,
    input  logic [CNT_W-1:0]  bit_period,
    input  logic [3:0]        wr_en,
    input  logic [7:0]        wr_data,
    output logic              ser_bit,
    output logic              bit_strobe,
    output logic              data_active,
    output logic              parity_err
);
    localparam logic [IDX_W-1:0] LAST_RUNIN = IDX_W'(RUNIN_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(RUNIN_BITS + FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] LAST_DATA  = IDX_W'(TOTAL_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_BASE  = IDX_W'(RUNIN_BITS + FRAME_BITS);

    cc_state_e        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] phase, limit, period_m1;
    logic             at_limit, trigger, in_tx;
    logic [7:0]       tx_first, tx_second, cur_byte;
    logic [IDX_W-1:0] data_pos;

    assign trigger   = (state_q == ST_IDLE) && line_start && (line_num == caption_line);
    assign in_tx     = (state_q == ST_RUNIN) || (state_q == ST_FRAME) || (state_q == ST_DATA);
    assign period_m1 = (bit_period == '0) ? '0 : bit_period - 1'b1;
    assign limit     = (state_q == ST_WAIT) ? start_delay : period_m1;

    cc_byte_bank #(.BYTE_W(8)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .load      (trigger),
        .load_odd  (field_odd),
        .tx_first  (tx_first),
        .tx_second (tx_second)
    );

    cc_phase_counter #(.CNT_W(CNT_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (state_q == ST_IDLE),
        .limit    (limit),
        .phase    (phase),
        .at_limit (at_limit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (!in_tx)
                idx_q <= '0;
            else if (at_limit)
                idx_q <= idx_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (trigger)                          state_d = ST_WAIT;
            ST_WAIT:  if (at_limit)                         state_d = ST_RUNIN;
            ST_RUNIN: if (at_limit && idx_q == LAST_RUNIN)  state_d = ST_FRAME;
            ST_FRAME: if (at_limit && idx_q == LAST_FRAME)  state_d = ST_DATA;
            ST_DATA:  if (at_limit && idx_q == LAST_DATA)   state_d = ST_IDLE;
            default:                                        state_d = ST_IDLE;
        endcase
    end

    assign data_pos = idx_q - DATA_BASE;
    assign cur_byte = data_pos[3] ? tx_second : tx_first;

    // outputs
    always_comb begin
        ser_bit     = 1'b0;
        parity_err  = 1'b0;
        data_active = in_tx;
        bit_strobe  = in_tx && (phase == '0);
        unique case (state_q)
            ST_IDLE, ST_WAIT: ser_bit = 1'b0;
            ST_RUNIN:         ser_bit = ~idx_q[0];
            ST_FRAME:         ser_bit = (idx_q == LAST_FRAME);
            ST_DATA: begin
                ser_bit    = cur_byte[data_pos[2:0]];
                parity_err = ~^cur_byte;
            end
            default:          ser_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cc_line_serializer_chk.sv
module cc_line_serializer_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_bit,
    input logic bit_strobe,
    input logic data_active,
    input logic parity_err
);
    AST_STROBE_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> data_active); // R4

    AST_BURST_OPENS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_active) |-> bit_strobe); // R3

    AST_RUNIN_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_active) |-> ser_bit); // R5

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_active && !bit_strobe) |-> $stable(ser_bit)); // R4

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !data_active |-> !ser_bit); // R12

    AST_PARITY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        parity_err |-> data_active); // R9
endmodule

bind cc_line_serializer cc_line_serializer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_bit     (ser_bit),
    .bit_strobe  (bit_strobe),
    .data_active (data_active),
    .parity_err  (parity_err)
);

// File: tb/sim_cc_line_serializer.sv
`timescale 1ns/1ps
module sim_cc_line_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        field_odd = 1'b1;
    logic [9:0]  line_num = '0;
    logic [9:0]  caption_line = 10'd21;
    logic [15:0] start_delay = '0;
    logic [15:0] bit_period = 16'd1;
    logic [3:0]  wr_en = '0;
    logic [7:0]  wr_data = '0;
    logic        ser_bit, bit_strobe, data_active, parity_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cc_line_serializer u0 (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .field_odd(field_odd),
        .line_num(line_num), .caption_line(caption_line), .start_delay(start_delay),
        .bit_period(bit_period), .wr_en(wr_en), .wr_data(wr_data),
        .ser_bit(ser_bit), .bit_strobe(bit_strobe), .data_active(data_active),
        .parity_err(parity_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic wr(input int sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 4'(1 << sel);
        wr_data = val;
        @(negedge clk);
        wr_en = '0;
    endtask

    // one triggered burst, every cycle compared; disturb = mid-burst writes plus line start
    task automatic run_tx(input bit odd, input int prog_p, input int d,
                          input logic [7:0] e0, input logic [7:0] e1, input bit disturb);
        int p = (prog_p == 0) ? 1 : prog_p;
        int len = d + 1 + 33 * p + 3;
        @(negedge clk);
        bit_period = 16'(prog_p);
        start_delay = 16'(d);
        field_odd = odd;
        line_num = caption_line;
        line_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        line_start = 1'b0;
        for (int cyc = 1; cyc <= len; cyc++) begin
            int rel;
            int k;
            bit ea, es, eb, ep;
            logic [7:0] by;
            @(posedge clk);
            @(negedge clk);
            rel = cyc - d - 1;
            ea = (rel >= 0) && (rel < 33 * p);
            k = ea ? rel / p : 0;
            es = ea && (rel % p == 0);
            eb = 1'b0;
            ep = 1'b0;
            if (ea) begin
                if (k < 14) eb = (k % 2 == 0);
                else if (k < 17) eb = (k == 16);
                else begin
                    by = (k < 25) ? e0 : e1;
                    eb = by[(k - 17) % 8];
                    ep = ~^by;
                end
            end
            check(disturb ? "R11" : "R3", "data_active", int'(data_active), int'(ea));
            check("R4", "bit_strobe", int'(bit_strobe), int'(es));
            check(!ea ? "R12" : (k < 14) ? "R5" : (k < 17) ? "R6" :
                  disturb ? "R10" : (odd ? "R7" : "R8"),
                  "ser_bit", int'(ser_bit), int'(eb));
            check("R9", "parity_err", int'(parity_err), int'(ep));
            if (disturb && cyc == d + 3) begin
                wr_en = 4'b1111;
                wr_data = 8'hA5;
                line_start = 1'b1;
            end else if (disturb && cyc == d + 4) begin
                wr_en = '0;
                line_start = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "data_active", int'(data_active), 0);
        check("R1", "bit_strobe", int'(bit_strobe), 0);
        check("R1", "ser_bit", int'(ser_bit), 0);
        check("R1", "parity_err", int'(parity_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: wrong line, no burst
        line_num = 10'd20;
        start_delay = 16'd2;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            check("R2", "data_active", int'(data_active), 0);
        end

        // sweep: periods 0..3, delays, both fields; R8 via distinct pairs
        for (int p = 0; p < 4; p++) begin
            for (int di = 0; di < 3; di++) begin
                for (int f = 0; f < 2; f++) begin
                    int d = (di == 0) ? 0 : (di == 1) ? 1 : 5;
                    logic [7:0] o0 = 8'(p * 37 + d * 11 + f * 90 + 3);
                    logic [7:0] o1 = 8'(p * 53 + d * 7 + f * 29 + 128);
                    logic [7:0] v0 = 8'(p * 19 + d * 41 + f * 13 + 66);
                    logic [7:0] v1 = 8'(p * 71 + d * 3 + f * 47 + 200);
                    wr(0, o0); wr(1, o1); wr(2, v0); wr(3, v1);
                    if (f == 1) run_tx(1'b1, p, d, o0, o1, 1'b0);
                    else        run_tx(1'b0, p, d, v0, v1, 1'b0);
                end
            end
        end

        // R10 / R11: write and line start mid-burst, then both fields see new bytes
        wr(0, 8'h01); wr(1, 8'h80); wr(2, 8'h0E); wr(3, 8'h7F);
        run_tx(1'b1, 2, 3, 8'h01, 8'h80, 1'b1);
        run_tx(1'b1, 1, 0, 8'hA5, 8'hA5, 1'b0);
        run_tx(1'b0, 1, 0, 8'hA5, 8'hA5, 1'b0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule